// File: doc/BRIEF.md
# Power-Management Event Block

This block is a fixed-function power-management register file on a simple I/O-style bus. It holds an event-status register, an event-enable register and a control register, and it runs a free-running power-management timer that advances on a single-cycle tick-enable input. A level-sensitive system control interrupt (`sci`) is driven from the enabled status bits and from an external hotplug event request.

Software clears status bits by writing ones to them. Clearing a pending timer-overflow status re-arms the next overflow mark at the next half-range boundary above the current count. A control write that carries the sleep-enable bit is decoded by sleep type. One type requests a soft power-off. Another type marks wake and power-button status, then requests a reset and flags a suspend-to-RAM entry. A separate command port turns the interrupt-enable control bit on and off, and a power-button input raises its status bit only when that event is enabled.

Writes carry 16 bits. Reads return a 32-bit word with the unused upper bits at zero. The timer readback is `TMR_W` bits wide, and the default is 24. Internally the count is kept wider so that the overflow mark can sit above the visible range.

Top module: `pm_evt_block`

## Requirements
- R1: After reset, every register reads zero, the timer reads zero, and `sci`, `shutdown_req`, `reset_req` and `s3_ind` are low.
- R2: Register offsets are status 0x00, enable 0x02, control 0x04 and timer 0x08. A read of any other offset returns zero, and a write to any other offset changes no register.
- R3: Each cycle with `tick_en` high advances the count by one. The timer reads back only its low `TMR_W` bits, and all read bits above them are zero.
- R4: The first overflow mark is 2^(TMR_W-1). Status bit 0 (timer overflow) goes high one cycle after the count reaches the mark, and it stays set until it is cleared.
- R5: A write to status clears each bit written as 1 and leaves each bit written as 0. Only bits 0, 8 and 15 are storage, and the other status bits read zero.
- R6: A write that clears a set timer-overflow bit re-arms the mark to the smallest multiple of 2^(TMR_W-1) that is strictly above the current count.
- R7: The enable register stores and returns all 16 written bits.
- R8: `sci` is high, in the same cycle, when (status AND enable) has bit 0, 5, 8 or 10 set, or when `gpe_req` is high.
- R9: A control write stores the written value with bit 13 (sleep enable) forced to zero.
- R10: A control write with bit 13 set and bits 12:10 equal to 0 gives a one-cycle `shutdown_req` pulse in the cycle after the write, with `reset_req` and `s3_ind` low.
- R11: A control write with bit 13 set and bits 12:10 equal to 1 sets status bits 15 (wake) and 8 (power button). In the cycle after the write it pulses `reset_req` and `s3_ind` for one cycle. Other sleep types give no pulse.
- R12: A `pwrbtn_evt` cycle sets status bit 8 only while enable bit 8 is set.
- R13: A command-port value of 0xF1 sets control bit 0, 0xF0 clears it, and any other value changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | One-cycle timer advance strobe |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | RD_W | Read data for `bus_addr` (combinational) |
| gpe_req | input | 1 | External hotplug event request (level) |
| pwrbtn_evt | input | 1 | Power-button event strobe |
| apm_valid | input | 1 | Command-port strobe |
| apm_cmd | input | 8 | Command-port value |
| sci | output | 1 | Level interrupt |
| shutdown_req | output | 1 | Soft power-off request pulse |
| reset_req | output | 1 | Resume reset request pulse |
| s3_ind | output | 1 | Suspend-to-RAM entry pulse |

## Verification
The assertions assume that the timer does not advance in the same cycle as a status write that re-arms it. They also assume that sleep writes are not issued back to back, so each request pulse stays one cycle wide, and that a command-port strobe does not coincide with a control write. The stimulus meets these assumptions: it drives every input on the falling clock edge, keeps `tick_en` low around every bus write, and separates each strobe from the next by at least one idle cycle. Timer behaviour is exercised with a narrow timer width so that two full overflow periods fit into a short run, including a re-arm taken exactly on a boundary.

// File: rtl/pm_evt_pkg.sv
package pm_evt_pkg;
  localparam int REG_W      = 16;
  localparam int OFS_STS    = 'h00;
  localparam int OFS_EN     = 'h02;
  localparam int OFS_CTL    = 'h04;
  localparam int OFS_TMR    = 'h08;

  localparam int B_TMR      = 0;
  localparam int B_GLOCK    = 5;
  localparam int B_PWRBTN   = 8;
  localparam int B_RTC      = 10;
  localparam int B_WAKE     = 15;

  localparam int C_SCIEN    = 0;
  localparam int C_SLPEN    = 13;
  localparam int C_SLPTYP   = 10;

  localparam logic [REG_W-1:0] SCI_MASK =
    (16'h1 << B_TMR) | (16'h1 << B_GLOCK) | (16'h1 << B_PWRBTN) | (16'h1 << B_RTC);
  localparam logic [REG_W-1:0] STS_IMPL =
    (16'h1 << B_TMR) | (16'h1 << B_PWRBTN) | (16'h1 << B_WAKE);

  localparam logic [7:0] APM_ON  = 8'hF1;
  localparam logic [7:0] APM_OFF = 8'hF0;

  localparam logic [2:0] SLP_SOFTOFF = 3'd0;
  localparam logic [2:0] SLP_SUSPEND = 3'd1;

  function automatic logic [2:0] sleep_kind(input logic [REG_W-1:0] v);
    return v[C_SLPTYP +: 3];
  endfunction
endpackage

// File: rtl/pm_evt_timer.sv
module pm_evt_timer #(
  parameter int TMR_W = 24,
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             rearm,
  output logic [CNT_W-1:0] cnt_o,
  output logic             hit
);
  localparam logic [CNT_W-1:0] HALF = {{(CNT_W-1){1'b0}}, 1'b1} << (TMR_W-1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] mark_q;

  // Next half-range boundary strictly above c.
  function automatic logic [CNT_W-1:0] next_mark(input logic [CNT_W-1:0] c);
    return (c + HALF) & ~(HALF - 1'b1);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      mark_q <= HALF;
    end else begin
      if (tick)  cnt_q  <= cnt_q + 1'b1;
      if (rearm) mark_q <= next_mark(cnt_q);
    end
  end

  assign cnt_o = cnt_q;
  assign hit   = (cnt_q >= mark_q);

  // R3: one step per tick
  assert_tick_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (cnt_q == $past(cnt_q) + 1'b1));
  // R6: the re-armed mark lies above the old count, on a boundary
  assert_rearm_mark_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rearm |=> ((mark_q > $past(cnt_q)) && ((mark_q & (HALF - 1'b1)) == '0)));
endmodule

// File: rtl/pm_evt_status.sv
module pm_evt_status
  import pm_evt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [REG_W-1:0] set_vec,
  input  logic [REG_W-1:0] clr_vec,
  output logic [REG_W-1:0] sts_o
);
  logic [REG_W-1:0] sts_q;

  // Set wins over a same-cycle clear; unimplemented bits stay zero.
  always_ff @(posedge clk) begin
    if (!rst_n) sts_q <= '0;
    else        sts_q <= ((sts_q & ~clr_vec) | set_vec) & STS_IMPL;
  end

  assign sts_o = sts_q;

  // R4: timer status only rises from a timer event
  assert_tmr_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sts_q[B_TMR]) |-> $past(set_vec[B_TMR]));
  // R5: a cleared bit without a new event reads zero next cycle
  assert_w1c_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_vec[B_PWRBTN] && !set_vec[B_PWRBTN]) |=> !sts_q[B_PWRBTN]);
endmodule

// File: rtl/pm_evt_ctrl.sv
module pm_evt_ctrl
  import pm_evt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_ctl,
  input  logic [REG_W-1:0] wdata,
  input  logic             apm_valid,
  input  logic [7:0]       apm_cmd,
  output logic [REG_W-1:0] ctl_o,
  output logic             wake_set,
  output logic             shutdown_req,
  output logic             reset_req,
  output logic             s3_ind
);
  logic [REG_W-1:0] ctl_q;
  logic             slp_go;
  logic [2:0]       slp_kind;
  logic             off_go;

  assign slp_go   = wr_ctl && wdata[C_SLPEN];
  assign slp_kind = sleep_kind(wdata);
  assign off_go   = slp_go && (slp_kind == SLP_SOFTOFF);
  assign wake_set = slp_go && (slp_kind == SLP_SUSPEND);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_q        <= '0;
      shutdown_req <= 1'b0;
      reset_req    <= 1'b0;
      s3_ind       <= 1'b0;
    end else begin
      if (wr_ctl) ctl_q <= wdata & ~(16'h1 << C_SLPEN);
      if (apm_valid && apm_cmd == APM_ON)  ctl_q[C_SCIEN] <= 1'b1;
      if (apm_valid && apm_cmd == APM_OFF) ctl_q[C_SCIEN] <= 1'b0;
      shutdown_req <= off_go;
      reset_req    <= wake_set;
      s3_ind       <= wake_set;
    end
  end

  assign ctl_o = ctl_q;

  // R9: sleep enable never stored
  assert_no_slpen_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_q[C_SLPEN]);
  // R10: power-off pulse only follows a sleep write
  assert_off_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
    shutdown_req |-> $past(wr_ctl && wdata[C_SLPEN]));
  // R11: reset request and suspend flag travel together
  assert_resume_pair_R11: assert property (@(posedge clk) disable iff (!rst_n)
    reset_req |-> (s3_ind && !shutdown_req));
  // R13: enable command sets the interrupt-enable bit
  assert_apm_on_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (apm_valid && apm_cmd == APM_ON) |=> ctl_q[C_SCIEN]);
endmodule

// File: rtl/pm_evt_block.sv
module pm_evt_block
  import pm_evt_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int RD_W   = 32,
  parameter int TMR_W  = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [REG_W-1:0]  bus_wdata,
  output logic [RD_W-1:0]   bus_rdata,
  input  logic              gpe_req,
  input  logic              pwrbtn_evt,
  input  logic              apm_valid,
  input  logic [7:0]        apm_cmd,
  output logic              sci,
  output logic              shutdown_req,
  output logic              reset_req,
  output logic              s3_ind
);
  localparam int CNT_W = TMR_W + 8;

  logic              sel_sts, sel_en, sel_ctl, sel_tmr;
  logic              wr_sts, wr_en, wr_ctl;
  logic [REG_W-1:0]  en_q;
  logic [REG_W-1:0]  sts;
  logic [REG_W-1:0]  ctl;
  logic [REG_W-1:0]  set_vec, clr_vec;
  logic [CNT_W-1:0]  cnt;
  logic              tmr_hit;
  logic              tmr_rearm;
  logic              wake_set;
  logic              pb_event;

  assign sel_sts = (bus_addr == ADDR_W'(OFS_STS));
  assign sel_en  = (bus_addr == ADDR_W'(OFS_EN));
  assign sel_ctl = (bus_addr == ADDR_W'(OFS_CTL));
  assign sel_tmr = (bus_addr == ADDR_W'(OFS_TMR));

  assign wr_sts = bus_wr && sel_sts;
  assign wr_en  = bus_wr && sel_en;
  assign wr_ctl = bus_wr && sel_ctl;

  // Clearing a pending overflow re-arms the mark.
  assign tmr_rearm = wr_sts && bus_wdata[B_TMR] && sts[B_TMR];
  assign pb_event  = pwrbtn_evt && en_q[B_PWRBTN];

  always_comb begin
    set_vec           = '0;
    set_vec[B_TMR]    = tmr_hit && !tmr_rearm;
    set_vec[B_PWRBTN] = pb_event || wake_set;
    set_vec[B_WAKE]   = wake_set;
    clr_vec           = wr_sts ? bus_wdata : '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     en_q <= '0;
    else if (wr_en) en_q <= bus_wdata;
  end

  pm_evt_timer #(.TMR_W(TMR_W), .CNT_W(CNT_W)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (tick_en),
    .rearm (tmr_rearm),
    .cnt_o (cnt),
    .hit   (tmr_hit)
  );

  pm_evt_status u_status (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_vec (set_vec),
    .clr_vec (clr_vec),
    .sts_o   (sts)
  );

  pm_evt_ctrl u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_ctl       (wr_ctl),
    .wdata        (bus_wdata),
    .apm_valid    (apm_valid),
    .apm_cmd      (apm_cmd),
    .ctl_o        (ctl),
    .wake_set     (wake_set),
    .shutdown_req (shutdown_req),
    .reset_req    (reset_req),
    .s3_ind       (s3_ind)
  );

  assign sci = (|(sts & en_q & SCI_MASK)) || gpe_req;

  always_comb begin
    bus_rdata = '0;
    if (sel_sts) bus_rdata = RD_W'(sts);
    if (sel_en)  bus_rdata = RD_W'(en_q);
    if (sel_ctl) bus_rdata = RD_W'(ctl);
    if (sel_tmr) bus_rdata = RD_W'(cnt[TMR_W-1:0]);
  end

  // R8: hotplug request always reaches the interrupt
  assert_gpe_sci_R8: assert property (@(posedge clk) disable iff (!rst_n)
    gpe_req |-> sci);
  // R12: power-button status rises only on an enabled press or a resume
  assert_pb_gate_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sts[B_PWRBTN]) |-> $past((pwrbtn_evt && en_q[B_PWRBTN]) || wake_set));
  // R2: unmapped offsets read zero
  assert_unmapped_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(sel_sts || sel_en || sel_ctl || sel_tmr) |-> (bus_rdata == '0));
endmodule

// File: tb/sim_pm_evt_block.sv
module sim_pm_evt_block;
  localparam int TW = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_en = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        gpe_req = 1'b0;
  logic        pwrbtn_evt = 1'b0;
  logic        apm_valid = 1'b0;
  logic [7:0]  apm_cmd = '0;
  logic        sci, shutdown_req, reset_req, s3_ind;

  int total = 0;
  int fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  pm_evt_block #(.ADDR_W(8), .RD_W(32), .TMR_W(TW)) u0 (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .gpe_req(gpe_req), .pwrbtn_evt(pwrbtn_evt), .apm_valid(apm_valid),
    .apm_cmd(apm_cmd), .sci(sci), .shutdown_req(shutdown_req),
    .reset_req(reset_req), .s3_ind(s3_ind)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] v);
    bus_addr = a;
    #1;
    v = bus_rdata;
  endtask

  task automatic ticks(input int n);
    @(negedge clk);
    tick_en = 1'b1;
    repeat (n) @(negedge clk);
    tick_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic int boundary_above(input int c);
    int half = 1 << (TW - 1);
    return ((c / half) + 1) * half;
  endfunction

  logic [31:0] v;

  task automatic t_reset;
    rd(8'h00, v); chk("R1 status", v, 0);
    rd(8'h02, v); chk("R1 enable", v, 0);
    rd(8'h04, v); chk("R1 control", v, 0);
    rd(8'h08, v); chk("R1 timer", v, 0);
    chk("R1 outputs", {28'd0, sci, shutdown_req, reset_req, s3_ind}, 0);
  endtask

  task automatic t_decode;
    wr(8'h06, 16'hBEEF);
    rd(8'h06, v); chk("R2 unmapped 0x06", v, 0);
    rd(8'h0A, v); chk("R2 unmapped 0x0A", v, 0);
    rd(8'h02, v); chk("R2 enable untouched", v, 0);
    rd(8'h04, v); chk("R2 control untouched", v, 0);
  endtask

  task automatic t_enable;
    wr(8'h02, 16'hFFFF);
    rd(8'h02, v); chk("R7 enable all ones", v, 32'hFFFF);
    chk("R8 no status no sci", {31'd0, sci}, 0);
    wr(8'h02, 16'h5A3C);
    rd(8'h02, v); chk("R7 enable pattern", v, 32'h5A3C);
    wr(8'h02, 16'h0000);
  endtask

  task automatic t_timer(inout int tc);
    ticks(100); tc += 100;
    rd(8'h08, v); chk("R3 timer after 100", v, 32'(tc));
  endtask

  task automatic t_overflow(inout int tc);
    int first = boundary_above(0);
    ticks(first - 1 - tc); tc = first - 1;
    idle(2);
    rd(8'h00, v); chk("R4 no status before mark", v, 0);
    @(negedge clk); tick_en = 1'b1;
    @(negedge clk); tick_en = 1'b0; tc++;
    rd(8'h00, v); chk("R4 status one cycle late", v, 0);
    @(negedge clk);
    rd(8'h00, v); chk("R4 status set at mark", v, 32'h0001);
    rd(8'h08, v); chk("R3 timer at mark", v, 32'(tc));
  endtask

  task automatic t_sci;
    wr(8'h02, 16'h0001);
    chk("R8 timer enabled sci", {31'd0, sci}, 1);
    wr(8'h02, 16'h0000);
    chk("R8 disabled sci low", {31'd0, sci}, 0);
    gpe_req = 1'b1; #1;
    chk("R8 gpe sci", {31'd0, sci}, 1);
    gpe_req = 1'b0; #1;
    chk("R8 gpe released", {31'd0, sci}, 0);
  endtask

  task automatic t_clear_rearm(inout int tc);
    int nxt;
    wr(8'h00, 16'hFFFE);
    rd(8'h00, v); chk("R5 zero bit keeps status", v, 32'h0001);
    wr(8'h00, 16'h0001);
    rd(8'h00, v); chk("R5 w1c clears", v, 0);
    nxt = boundary_above(tc);
    ticks(nxt - 1 - tc); tc = nxt - 1;
    idle(2);
    rd(8'h00, v); chk("R6 not set before new mark", v, 0);
    ticks(1); tc++;
    idle(1);
    rd(8'h00, v); chk("R6 set at re-armed mark", v, 32'h0001);
    rd(8'h08, v); chk("R3 upper bits dropped", v, 32'(tc % (1 << TW)));
    wr(8'h00, 16'h0001);
    rd(8'h00, v); chk("R6 cleared again", v, 0);
  endtask

  task automatic t_pwrbtn;
    @(negedge clk); pwrbtn_evt = 1'b1;
    @(negedge clk); pwrbtn_evt = 1'b0;
    rd(8'h00, v); chk("R12 disabled press ignored", v, 0);
    wr(8'h02, 16'h0100);
    @(negedge clk); pwrbtn_evt = 1'b1;
    @(negedge clk); pwrbtn_evt = 1'b0;
    rd(8'h00, v); chk("R12 enabled press", v, 32'h0100);
    chk("R8 power button sci", {31'd0, sci}, 1);
    wr(8'h00, 16'h0100);
    rd(8'h00, v); chk("R5 power button cleared", v, 0);
    wr(8'h02, 16'h0000);
  endtask

  task automatic t_ctrl;
    wr(8'h04, 16'h00A5);
    rd(8'h04, v); chk("R9 control store", v, 32'h00A5);
    wr(8'h04, 16'h2801);
    chk("R11 other type no pulse", {29'd0, shutdown_req, reset_req, s3_ind}, 0);
    rd(8'h04, v); chk("R9 sleep enable dropped", v, 32'h0801);
    rd(8'h00, v); chk("R11 other type no status", v, 0);
  endtask

  task automatic t_softoff;
    wr(8'h04, 16'h2000);
    chk("R10 off pulse", {29'd0, shutdown_req, reset_req, s3_ind}, 3'b100);
    @(negedge clk);
    chk("R10 off pulse ends", {29'd0, shutdown_req, reset_req, s3_ind}, 0);
    rd(8'h04, v); chk("R9 control after off", v, 0);
  endtask

  task automatic t_suspend;
    wr(8'h04, 16'h2400);
    chk("R11 resume pulses", {29'd0, shutdown_req, reset_req, s3_ind}, 3'b011);
    @(negedge clk);
    chk("R11 pulses end", {29'd0, shutdown_req, reset_req, s3_ind}, 0);
    rd(8'h00, v); chk("R11 wake and button status", v, 32'h8100);
    wr(8'h00, 16'hFFFF);
    rd(8'h00, v); chk("R5 clear all", v, 0);
  endtask

  task automatic apm(input logic [7:0] c);
    @(negedge clk); apm_valid = 1'b1; apm_cmd = c;
    @(negedge clk); apm_valid = 1'b0;
  endtask

  task automatic t_apm;
    apm(8'hF1);
    rd(8'h04, v); chk("R13 enable command", v, 32'h0401);
    apm(8'h33);
    rd(8'h04, v); chk("R13 other command ignored", v, 32'h0401);
    apm(8'hF0);
    rd(8'h04, v); chk("R13 disable command", v, 32'h0400);
  endtask

  initial begin
    int tc = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_decode();
    t_enable();
    t_timer(tc);
    t_overflow(tc);
    t_sci();
    t_clear_rearm(tc);
    t_pwrbtn();
    t_ctrl();
    t_softoff();
    t_suspend();
    t_apm();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; fails++;
      $display("FAIL watchdog actual=%h expected=%h", 1, 0);
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule